// File: doc/BRIEF.md
# Compact Register-Mapped Serial Port

This block is an asynchronous serial port for a chip's control bus. It has a small set of word-spaced registers, laid out like a reduced version of the classic 16550 map. Software writes bytes into an eight-entry transmit queue. A shifter sends each byte on `txd` as one start bit, seven or eight data bits sent LSB first, and one stop bit. There is no parity. A receiver oversamples `rxd` eight times per bit and places complete symbols in an eight-entry receive queue, which software drains by reading the data register.

The bit period is eight times the 16-bit value held in the baud register, counted in system clock cycles. A divisor of 0 acts as 1. Transmit and receive each have their own enable. Software sets the RTS line directly and reads the CTS line through a modem-status bit. A line-control bit holds `txd` low to send a break. A single level interrupt signals that receive data is waiting or that the transmit queue has room. Each source has its own enable bit. Two further gate bits in the same register must both be set before either source can reach the output pin.

Register index = `addr[5:2]`: 0 data, 1 interrupt enable, 2 interrupt identify, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 8 extra control, 9 extra status, 10 baud.

Top module: `compact_uart`

## Requirements
- R1: After reset, line status reads 0x60, `irq` is 0, `txd` is 1 and `rts_out` is 0.
- R2: In 8-bit mode (line control [1:0] = 11), each byte written to data is sent as a low start bit, then 8 data bits LSB first, then a high stop bit. Each bit lasts 8 × baud clock cycles.
- R3: In 7-bit mode (line control [1:0] = 00), only data bits [6:0] are sent, followed by the stop bit.
- R4: Received bytes are read from the data register in arrival order. Line status bit 0 and extra status bit 0 are 1 while at least one byte is waiting.
- R5: In 7-bit mode, 7 data bits are received and the byte is returned with bit 7 equal to 0.
- R6: A symbol that completes while the receive queue holds 8 entries is dropped and sets line status bit 1. That bit clears after a line status read.
- R7: The transmit queue holds 8 bytes. Line status bit 5 is 0 while the queue is full, and writes made then are dropped. Line status bit 6 is 1 only when the queue is empty and the shifter is idle.
- R8: `irq` = ien[3] & ien[2] & ((ien[0] & rx waiting) | (ien[1] & tx room)).
- R9: Interrupt identify reads bit 2 = rx waiting, bit 1 = tx room and no rx waiting, bit 0 = NOT `irq`.
- R10: Writing interrupt identify with bit 1 set empties the receive queue. Writing it with bit 2 set empties the transmit queue.
- R11: While line control bit 6 is 1, `txd` is 0.
- R12: Modem control bit 1 drives `rts_out` from the cycle after the write. Modem status bit 5 shows `cts_in` after a two-flop synchronizer.
- R13: With extra control bit 0 clear, activity on `rxd` is ignored. With extra control bit 1 clear, queued bytes are held and `txd` stays high.
- R14: The scratch register and the baud register read back what was written. Unsupported bits read 0: interrupt enable keeps [3:0], line control keeps [1:0] and [6], modem control keeps [1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Byte address; bits [5:2] select the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops the receive queue or clears overrun |
| rd_data | output | 32 | Read data, combinational from `addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rts_out | output | 1 | Software-driven RTS |
| cts_in | input | 1 | CTS input |
| irq | output | 1 | Level interrupt |

## Verification
The transmit path is tested with several byte sets: alternating patterns, values with the top bit set in 7-bit mode (to show that bit 7 is removed), and nine back-to-back writes while transmit is disabled (to show where the queue depth cuts off). The receive path gets single bytes, an all-ones byte, a 7-bit symbol, and a burst of nine with no reads in between. That burst separates correct dropping of the overflow symbol from wrong overwriting of the oldest entry. The interrupt tests run the enable mask with and without the gate bits, with data present and absent. This separates the gate logic from the source logic and confirms the receive-first identify encoding.

// File: rtl/compact_uart_pkg.sv
package compact_uart_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      IDX_DATA  = 4'h0,
      IDX_IEN   = 4'h1,
      IDX_IID   = 4'h2,
      IDX_LINE  = 4'h3,
      IDX_MCTL  = 4'h4,
      IDX_LSTAT = 4'h5,
      IDX_MSTAT = 4'h6,
      IDX_SCR   = 4'h7,
      IDX_XCTL  = 4'h8,
      IDX_XSTAT = 4'h9,
      IDX_BAUD  = 4'hA
   } reg_idx_e;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_sync.sv
module uart_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_stage_chk
      $error("uart_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rp_q];

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else if (clr) begin
         wp_q <= '0; rp_q <= '0; cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= bump(wp_q);
         if (do_pop)  rp_q <= bump(rp_q);
         if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
         else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, div};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
   parameter int OVS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       wlen8,
   input  logic       q_empty,
   input  logic [7:0] q_head,
   output logic       pop,
   output logic       line,
   output logic       busy
);
   localparam int SW = $clog2(OVS);

   logic [9:0]    sh_q;
   logic [3:0]    left_q;
   logic [SW-1:0] sub_q;

   assign pop  = en && !busy && !q_empty;
   assign line = busy ? sh_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '1; left_q <= '0; sub_q <= '0; busy <= 1'b0;
      end else if (pop) begin
         sh_q   <= {1'b1, (wlen8 ? q_head[7] : 1'b1), q_head[6:0], 1'b0};
         left_q <= wlen8 ? 4'd10 : 4'd9;
         sub_q  <= '0;
         busy   <= 1'b1;
      end else if (busy && tick) begin
         if (sub_q == SW'(OVS - 1)) begin
            sub_q  <= '0;
            sh_q   <= {1'b1, sh_q[9:1]};
            left_q <= left_q - 4'd1;
            if (left_q == 4'd1) busy <= 1'b0;
         end else begin
            sub_q <= sub_q + SW'(1);
         end
      end
   end
endmodule

// File: rtl/uart_rx.sv
module uart_rx import compact_uart_pkg::*; #(
   parameter int OVS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       en,
   input  logic       wlen8,
   input  logic       line,
   output logic       valid,
   output logic [7:0] data
);
   localparam int SW = $clog2(OVS);

   rx_state_e     st_q;
   logic [SW-1:0] sub_q;
   logic [2:0]    nb_q;
   logic [7:0]    sh_q;
   logic          prev_q;

   assign data = wlen8 ? sh_q : {1'b0, sh_q[7:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RX_IDLE; sub_q <= '0; nb_q <= '0; sh_q <= '0;
         prev_q <= 1'b1; valid <= 1'b0;
      end else begin
         prev_q <= line;
         valid  <= 1'b0;
         case (st_q)
            RX_IDLE: if (en && prev_q && !line) begin
               st_q <= RX_START; sub_q <= '0;
            end
            RX_START: if (tick) begin
               if (sub_q == SW'(OVS/2 - 1)) begin
                  sub_q <= '0; nb_q <= '0;
                  st_q  <= line ? RX_IDLE : RX_DATA;
               end else sub_q <= sub_q + SW'(1);
            end
            RX_DATA: if (tick) begin
               if (sub_q == SW'(OVS - 1)) begin
                  sub_q <= '0;
                  sh_q  <= {line, sh_q[7:1]};
                  nb_q  <= nb_q + 3'd1;
                  if (nb_q == (wlen8 ? 3'd7 : 3'd6)) st_q <= RX_STOP;
               end else sub_q <= sub_q + SW'(1);
            end
            RX_STOP: if (tick) begin
               if (sub_q == SW'(OVS - 1)) begin
                  st_q <= RX_IDLE; valid <= 1'b1;
               end else sub_q <= sub_q + SW'(1);
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/compact_uart.sv
module compact_uart import compact_uart_pkg::*; #(
   parameter int DW          = 32,
   parameter int AW          = 6,
   parameter int FIFO_DEPTH  = 8,
   parameter int DIV_W       = 16,
   parameter int OVS         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   input  logic          rxd,
   output logic          txd,
   output logic          rts_out,
   input  logic          cts_in,
   output logic          irq
);
   if (AW != 6) begin : g_aw_chk
      $error("compact_uart: AW must be 6");
   end
   if (DIV_W < BYTE_W || DW < DIV_W) begin : g_dw_chk
      $error("compact_uart: need BYTE_W <= DIV_W <= DW");
   end
   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_ovs_chk
      $error("compact_uart: OVS must be a power of two >= 4");
   end
   if (FIFO_DEPTH < 2) begin : g_depth_chk
      $error("compact_uart: FIFO_DEPTH must be at least 2");
   end

   reg_idx_e         idx;
   logic [3:0]       ien_q;
   logic [1:0]       line_q;
   logic             brk_q, rts_q, rx_en_q, tx_en_q, ovr_q;
   logic [7:0]       scr_q;
   logic [DIV_W-1:0] baud_q;
   logic             tick, rx_s, cts_s, wlen8;
   logic             rx_valid, rx_full, rx_empty, rx_pop, rx_clr;
   logic [7:0]       rx_byte, rx_head;
   logic             tx_full, tx_empty, tx_pop, tx_push, tx_clr, tx_busy, tx_line;
   logic [7:0]       tx_head;
   logic             rx_avail, tx_space, tx_idle;
   logic [2:0]       iid;

   assign idx      = reg_idx_e'(addr[5:2]);
   assign wlen8    = (line_q == 2'b11);
   assign rx_avail = !rx_empty;
   assign tx_space = !tx_full;
   assign tx_idle  = tx_empty && !tx_busy;
   assign rx_pop   = rd_en && (idx == IDX_DATA);
   assign tx_push  = wr_en && (idx == IDX_DATA);
   assign rx_clr   = wr_en && (idx == IDX_IID) && wr_data[1];
   assign tx_clr   = wr_en && (idx == IDX_IID) && wr_data[2];
   assign irq      = ien_q[3] && ien_q[2] &&
                     ((ien_q[0] && rx_avail) || (ien_q[1] && tx_space));
   assign iid      = {rx_avail, !rx_avail && tx_space, !irq};
   assign txd      = brk_q ? 1'b0 : tx_line;
   assign rts_out  = rts_q;

   uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s));
   uart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cts_sync (
      .clk(clk), .rst_n(rst_n), .d(cts_in), .q(cts_s));

   uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(baud_q), .tick(tick));

   uart_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
      .din(wr_data[7:0]), .pop(tx_pop), .head(tx_head),
      .empty(tx_empty), .full(tx_full));

   uart_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_valid),
      .din(rx_byte), .pop(rx_pop), .head(rx_head),
      .empty(rx_empty), .full(rx_full));

   uart_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(tx_en_q), .wlen8(wlen8),
      .q_empty(tx_empty), .q_head(tx_head), .pop(tx_pop),
      .line(tx_line), .busy(tx_busy));

   uart_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en_q), .wlen8(wlen8),
      .line(rx_s), .valid(rx_valid), .data(rx_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0; line_q <= '0; brk_q <= 1'b0; rts_q <= 1'b0;
         scr_q <= '0; rx_en_q <= 1'b0; tx_en_q <= 1'b0; baud_q <= '0;
      end else if (wr_en) begin
         case (idx)
            IDX_IEN:  ien_q  <= wr_data[3:0];
            IDX_LINE: begin line_q <= wr_data[1:0]; brk_q <= wr_data[6]; end
            IDX_MCTL: rts_q  <= wr_data[1];
            IDX_SCR:  scr_q  <= wr_data[7:0];
            IDX_XCTL: begin rx_en_q <= wr_data[0]; tx_en_q <= wr_data[1]; end
            IDX_BAUD: baud_q <= wr_data[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ovr_q <= 1'b0;
      else if (rx_valid && rx_full)           ovr_q <= 1'b1;
      else if (rd_en && (idx == IDX_LSTAT))   ovr_q <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      case (idx)
         IDX_DATA:  rd_data[7:0] = rx_empty ? 8'h00 : rx_head;
         IDX_IEN:   rd_data[3:0] = ien_q;
         IDX_IID:   rd_data[2:0] = iid;
         IDX_LINE:  begin rd_data[1:0] = line_q; rd_data[6] = brk_q; end
         IDX_MCTL:  rd_data[1] = rts_q;
         IDX_LSTAT: begin
            rd_data[0] = rx_avail; rd_data[1] = ovr_q;
            rd_data[5] = tx_space; rd_data[6] = tx_idle;
         end
         IDX_MSTAT: rd_data[5] = cts_s;
         IDX_SCR:   rd_data[7:0] = scr_q;
         IDX_XCTL:  rd_data[1:0] = {tx_en_q, rx_en_q};
         IDX_XSTAT: rd_data[1:0] = {tx_space, rx_avail};
         IDX_BAUD:  rd_data[DIV_W-1:0] = baud_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/compact_uart_chk.sv
module compact_uart_chk #(
   parameter int DW = 32,
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] addr,
   input logic          wr_en,
   input logic [DW-1:0] wr_data,
   input logic          rd_en,
   input logic [DW-1:0] rd_data,
   input logic          txd,
   input logic          rts_out,
   input logic          irq,
   input logic          brk,
   input logic          tx_busy,
   input logic [3:0]    ien,
   input logic          rx_valid,
   input logic          rx_full,
   input logic          ovr
);
   // R11
   break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> !txd);

   // R2
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && !brk) |-> txd);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien[3:2] == 2'b11));

   // R12
   rts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[5:2] == 4'h4) |=> (rts_out == $past(wr_data[1])));

   // R6
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full) |=> ovr);

   // R9
   iid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[5:2] == 4'h2) |-> $onehot0(rd_data[2:1]));
endmodule

bind compact_uart compact_uart_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .txd(txd), .rts_out(rts_out), .irq(irq),
   .brk(brk_q), .tx_busy(tx_busy), .ien(ien_q), .rx_valid(rx_valid),
   .rx_full(rx_full), .ovr(ovr_q));

// File: tb/compact_uart_test.sv
`timescale 1ns/1ps
module compact_uart_test;
   localparam int BIT = 16;   // baud 2 -> 8 ticks x 2 cycles

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        rxd = 1'b1, cts_in = 1'b0;
   logic        txd, rts_out, irq;

   int checks = 0, failures = 0;
   logic m_rts = 1'b0, m_brk = 1'b0, m_wlen8 = 1'b0, mon_en = 1'b1, run = 1'b0;
   logic [7:0] got[$];
   logic [7:0] expq[$];

   always #2.5 clk = ~clk;

   compact_uart uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rxd(rxd), .txd(txd),
      .rts_out(rts_out), .cts_in(cts_in), .irq(irq));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk); addr = a[5:0]; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      if (a == 12) begin m_brk = d[6]; m_wlen8 = (d[1:0] == 2'b11); end
      if (a == 16) m_rts = d[1];
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk); addr = a[5:0]; rd_en = 1'b1;
      #1 v = int'(rd_data);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input int exp);
      int v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic send(input logic [7:0] b, input int nb);
      @(negedge clk); rxd = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = b[i];
         repeat (BIT) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (BIT + 6) @(negedge clk);
   endtask

   task automatic wait_frames(input int n);
      repeat (n * 10 * BIT + 60) @(negedge clk);
   endtask

   task automatic expect_line(input string req);
      check(req, got.size(), expq.size());
      while (got.size() > 0 && expq.size() > 0)
         check(req, got.pop_front(), expq.pop_front());
      got.delete(); expq.delete();
   endtask

   // behavioural line decoder for txd
   initial begin
      forever begin
         int nb;
         logic [7:0] b;
         @(negedge txd);
         if (mon_en) begin
            nb = m_wlen8 ? 8 : 7;
            b  = '0;
            repeat (BIT/2) @(posedge clk);
            for (int i = 0; i < nb; i++) begin
               repeat (BIT) @(posedge clk); #1 b[i] = txd;
            end
            repeat (BIT) @(posedge clk); #1;
            check(nb == 8 ? "R2 stop" : "R3 stop", int'(txd), 1);
            got.push_back(b);
         end
      end
   end

   // per-clock comparison against the model
   always @(posedge clk) begin
      #2;
      if (run) begin
         check("R12 rts", int'(rts_out), int'(m_rts));
         if (m_brk) check("R11 break", int'(txd), 0);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      run = 1'b1;
      // R1 reset state
      rd_chk("R1 lsr", 20, 'h60);
      check("R1 irq", int'(irq), 0);
      check("R1 txd", int'(txd), 1);
      check("R1 rts", int'(rts_out), 0);

      wr(40, 2); wr(12, 3); wr(32, 3);

      // R2 8-bit transmit
      wr(0, 'h5A); wr(0, 'h81);
      expq.push_back(8'h5A); expq.push_back(8'h81);
      wait_frames(2);
      expect_line("R2");

      // R3 7-bit transmit drops bit 7
      wr(12, 0); wr(0, 'hC5); expq.push_back(8'h45);
      wait_frames(1);
      expect_line("R3");
      wr(12, 3);

      // R4 receive in order
      send(8'h12, 8); send(8'hA7, 8); send(8'hFF, 8);
      rd_chk("R4 lsr", 20, 'h61);
      rd_chk("R4 xstat", 36, 'h03);
      rd_chk("R4 d0", 0, 'h12);
      rd_chk("R4 d1", 0, 'hA7);
      rd_chk("R4 d2", 0, 'hFF);
      rd_chk("R4 lsr empty", 20, 'h60);

      // R5 7-bit receive
      wr(12, 0); send(8'hD3, 7);
      rd_chk("R5 data", 0, 'h53);
      wr(12, 3);

      // R6 overrun
      for (int i = 0; i < 9; i++) send(8'(i * 17 + 3), 8);
      rd_chk("R6 lsr ovr", 20, 'h63);
      rd_chk("R6 lsr cleared", 20, 'h61);
      for (int i = 0; i < 8; i++) rd_chk("R6 data", 0, i * 17 + 3);

      // R7 / R13 transmit queue depth and tx disable
      wr(32, 1);
      for (int i = 0; i < 9; i++) wr(0, 'h30 + i);
      rd_chk("R7 lsr full", 20, 'h00);
      repeat (3 * BIT) @(negedge clk);
      check("R13 txd held", int'(txd), 1);
      for (int i = 0; i < 8; i++) expq.push_back(8'(8'h30 + i));
      wr(32, 3);
      wait_frames(9);
      expect_line("R7");
      rd_chk("R7 lsr idle", 20, 'h60);

      // R13 receive disabled
      wr(32, 2); send(8'h77, 8);
      rd_chk("R13 rx ignored", 20, 'h60);
      wr(32, 3);

      // R8 / R9 interrupt gating and identify
      wr(4, 'h03);
      check("R8 no gate", int'(irq), 0);
      wr(4, 'h0D);
      check("R8 rx only empty", int'(irq), 0);
      send(8'h44, 8);
      check("R8 rx irq", int'(irq), 1);
      rd_chk("R9 iid rx", 8, 'h04);
      rd_chk("R8 drain", 0, 'h44);
      wr(4, 'h0E);
      check("R8 tx irq", int'(irq), 1);
      rd_chk("R9 iid tx", 8, 'h02);
      wr(4, 0);
      rd_chk("R9 iid none", 8, 'h03);

      // R10 queue clears
      send(8'h99, 8);
      wr(8, 'h02);
      rd_chk("R10 rx clear", 20, 'h60);
      wr(32, 1);
      wr(0, 1); wr(0, 2); wr(0, 3);
      wr(8, 'h04);
      rd_chk("R10 tx clear", 20, 'h60);
      wr(32, 3);
      wait_frames(3);
      expect_line("R10");

      // R11 / R14 break and masked bits
      mon_en = 1'b0;
      wr(12, 'hFF);
      rd_chk("R14 lcr", 12, 'h43);
      check("R11 txd", int'(txd), 0);
      wr(12, 3);
      repeat (40) @(negedge clk);
      mon_en = 1'b1;
      wr(16, 'hFF);
      rd_chk("R14 mcr", 16, 'h02);
      check("R12 rts", int'(rts_out), 1);
      wr(4, 'hFF);
      rd_chk("R14 ien", 4, 'h0F);
      wr(4, 0);
      wr(28, 'hA5);
      rd_chk("R14 scratch", 28, 'hA5);
      rd_chk("R14 baud", 40, 2);
      wr(16, 0);

      // R12 CTS through synchronizer
      cts_in = 1'b1; repeat (4) @(negedge clk);
      rd_chk("R12 cts hi", 24, 'h20);
      cts_in = 1'b0; repeat (4) @(negedge clk);
      rd_chk("R12 cts lo", 24, 'h00);
      check("R12 irq quiet", int'(irq), 0);

      run = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule